// File: doc/BRIEF.md
# Receive Error Performance Counters

This block keeps four saturating 16-bit tallies of receive error events: framing-bit errors, CRC errors, line code violations and far-end block errors. Each event arrives as a one-cycle strobe from the detection logic upstream. Software reads the tallies through a small register read port.

Two readout modes exist, and a configuration bit picks one. In clear-on-read mode a read returns the live tally and zeroes it. In snapshot mode every one-second tick copies all four live tallies into holding registers at once and restarts the live tallies. Reads then return the held copies and clear nothing. A separate stop bit suspends all counting while any receive alarm is raised: loss of frame, loss of signal or alarm indication signal.

The same one-second tick sets a sticky status flag. Software reads and clears that flag through the read port.

Top module: `pm_err_counters`

## Requirements
- R1: After reset, all four tallies, all four held copies and the one-second flag are zero. `sec_irq_o` is low.
- R2: Each strobe on `event_i` adds one to its own tally only. The bit mapping is: bit 0 framing-bit, bit 1 CRC, bit 2 line code violation, bit 3 far-end block. Read addresses 0 to 3 select the tallies in the same order.
- R3: A tally that has reached 0xFFFF stays at 0xFFFF when further strobes arrive. It never wraps.
- R4: With `cfg_latch_i` low, a read of address 0 to 3 returns the live tally on `rd_data_o` in the cycle that `rd_en_i` is high. The tally is zero after that cycle.
- R5: With `cfg_latch_i` low, a strobe in the same cycle as a read of its tally is kept. The tally becomes 1, not 0.
- R6: With `cfg_latch_i` high, a `sec_tick_i` cycle copies all four live tallies into their held copies together. Reads of addresses 0 to 3 return the held copies, and repeated reads return the same value.
- R7: With `cfg_latch_i` high, each live tally restarts on the tick. A strobe in the tick cycle is counted into the new interval, so the tally starts at 1. The held copy receives the value from before the tick.
- R8: With `cfg_stop_i` high and any of `lof_i`, `los_i` or `ais_i` high, strobes have no effect on any tally.
- R9: With `cfg_stop_i` low, strobes are counted normally while the alarms are high.
- R10: `sec_tick_i` sets a sticky flag, which is visible on `sec_irq_o` and on bit 0 of address 4. A read of address 4 returns the flag and clears it, unless a tick arrives in the same cycle, in which case the flag stays set.
- R11: Addresses 5 to 7 read as zero. `rd_data_o` is zero whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 4 | Error strobes, one bit per error kind |
| sec_tick_i | input | 1 | One-second timer pulse |
| lof_i | input | 1 | Loss-of-frame alarm level |
| los_i | input | 1 | Loss-of-signal alarm level |
| ais_i | input | 1 | Alarm indication signal level |
| cfg_latch_i | input | 1 | 1 = snapshot mode, 0 = clear-on-read mode |
| cfg_stop_i | input | 1 | 1 = suspend counting during alarms |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data, valid in the cycle of the read |
| sec_irq_o | output | 1 | Sticky one-second status flag |

## Verification
The internal state can go wrong in three ways. A tally that wrapped or missed a clear shows up at the very next read of that address, as a value that differs from the count of strobes sent since the last clear or tick. A held copy that drifts between ticks shows up when the same address is read twice in a row and the two values differ. An inhibit that leaks, or a flag that fails to stick, shows up one cycle later, on the following read or on `sec_irq_o`.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int PM_NUM = 4;

    typedef enum logic [2:0] {
        PM_SEL_FRAME = 3'd0,
        PM_SEL_CRC   = 3'd1,
        PM_SEL_LCV   = 3'd2,
        PM_SEL_FEBE  = 3'd3,
        PM_SEL_STAT  = 3'd4
    } pm_sel_e;
endpackage

// File: rtl/pm_cnt_slice.sv
module pm_cnt_slice #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clear_i,
    input  logic             snap_i,
    output logic [CNT_W-1:0] live_o,
    output logic [CNT_W-1:0] hold_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] hold;
    } slice_t;

    slice_t st_d, st_q;
    logic [CNT_W-1:0] restart_val;

    always_comb begin
        st_d        = st_q;
        restart_val = inc_i ? CNT_ONE : '0;
        if (snap_i) begin
            st_d.hold = st_q.live;
            st_d.live = restart_val;
        end else if (clear_i) begin
            st_d.live = restart_val;
        end else if (inc_i && st_q.live != CNT_MAX) begin
            st_d.live = st_q.live + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_o = st_q.live;
    assign hold_o = st_q.hold;

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live == CNT_MAX && inc_i && !clear_i && !snap_i) |=> st_q.live == CNT_MAX);
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !inc_i) |=> st_q.live == '0);
    assert_clear_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && inc_i) |=> st_q.live == CNT_ONE);
    assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(st_q.hold));
    assert_restart_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_i && inc_i) |=> st_q.live == CNT_ONE);
endmodule

// File: rtl/pm_sec_flag.sv
module pm_sec_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (set_i)      fl_d.flag = 1'b1;
        else if (clr_i) fl_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flag_o = fl_q.flag;

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/pm_err_counters.sv
module pm_err_counters
    import pm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PM_NUM-1:0] event_i,
    input  logic              sec_tick_i,
    input  logic              lof_i,
    input  logic              los_i,
    input  logic              ais_i,
    input  logic              cfg_latch_i,
    input  logic              cfg_stop_i,
    input  logic              rd_en_i,
    input  logic [2:0]        rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              sec_irq_o
);
    logic                          alarm_any;
    logic                          count_ok;
    logic                          snap;
    logic                          stat_rd;
    logic [PM_NUM-1:0]             inc;
    logic [PM_NUM-1:0]             rd_clr;
    logic [PM_NUM-1:0][CNT_W-1:0]  live;
    logic [PM_NUM-1:0][CNT_W-1:0]  hold;
    logic                          sec_flag;

    assign alarm_any = lof_i | los_i | ais_i;
    assign count_ok  = !(cfg_stop_i && alarm_any);
    assign snap      = cfg_latch_i && sec_tick_i;
    assign stat_rd   = rd_en_i && (rd_addr_i == PM_SEL_STAT);

    for (genvar g = 0; g < PM_NUM; g++) begin : g_cnt
        assign inc[g]    = event_i[g] && count_ok;
        assign rd_clr[g] = rd_en_i && !cfg_latch_i && (rd_addr_i == 3'(g));

        pm_cnt_slice #(.CNT_W(CNT_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc[g]),
            .clear_i (rd_clr[g]),
            .snap_i  (snap),
            .live_o  (live[g]),
            .hold_o  (hold[g])
        );
    end

    pm_sec_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sec_tick_i),
        .clr_i  (stat_rd),
        .flag_o (sec_flag)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            if (rd_addr_i < 3'(PM_NUM)) begin
                rd_data_o = cfg_latch_i ? hold[rd_addr_i[1:0]] : live[rd_addr_i[1:0]];
            end else if (rd_addr_i == PM_SEL_STAT) begin
                rd_data_o = {{(CNT_W-1){1'b0}}, sec_flag};
            end
        end
    end

    assign sec_irq_o = sec_flag;

    assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stop_i && alarm_any && !sec_tick_i && !rd_en_i) |=> $stable(live));
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> rd_data_o == '0);
endmodule

// File: tb/pm_err_counters_tb.sv
module pm_err_counters_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  event_i = '0;
    logic        sec_tick_i = 1'b0;
    logic        lof_i = 1'b0, los_i = 1'b0, ais_i = 1'b0;
    logic        cfg_latch_i = 1'b0, cfg_stop_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [2:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic        sec_irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    pm_err_counters u_dut (
        .clk(clk), .rst_n(rst_n), .event_i(event_i), .sec_tick_i(sec_tick_i),
        .lof_i(lof_i), .los_i(los_i), .ais_i(ais_i),
        .cfg_latch_i(cfg_latch_i), .cfg_stop_i(cfg_stop_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .sec_irq_o(sec_irq_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] mask, input int n);
        event_i = mask;
        repeat (n) @(negedge clk);
        event_i = '0;
    endtask

    task automatic rd(input logic [2:0] addr, output int val);
        rd_en_i   = 1'b1;
        rd_addr_i = addr;
        #1 val = rd_data_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        check("R1 sec_irq", sec_irq_o, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 0);
        end
    endtask

    task automatic t_count();
        int v;
        pulse(4'b0001, 3);
        pulse(4'b0010, 5);
        pulse(4'b0100, 7);
        pulse(4'b1000, 2);
        pulse(4'b1111, 1);
        rd(3'd0, v); check("R2 framing", v, 4);
        rd(3'd1, v); check("R2 crc", v, 6);
        rd(3'd2, v); check("R2 lcv", v, 8);
        rd(3'd3, v); check("R2 febe", v, 3);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            check("R4 cleared after read", v, 0);
        end
    endtask

    task automatic t_collide();
        int v;
        pulse(4'b0010, 4);
        event_i = 4'b0010;
        rd(3'd1, v);
        event_i = '0;
        check("R5 read value", v, 4);
        rd(3'd1, v);
        check("R5 kept strobe", v, 1);
    endtask

    task automatic t_stop();
        int v;
        cfg_stop_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            lof_i = (k == 0); los_i = (k == 1); ais_i = (k == 2);
            pulse(4'b1111, 5);
            for (int a = 0; a < 4; a++) begin
                rd(3'(a), v);
                check("R8 inhibited", v, 0);
            end
        end
        lof_i = 0; los_i = 0; ais_i = 0;
        pulse(4'b1111, 2);
        rd(3'd0, v); check("R8 resumes after alarm", v, 2);
        for (int a = 1; a < 4; a++) rd(3'(a), v);
        cfg_stop_i = 1'b0;
    endtask

    task automatic t_nostop();
        int v;
        lof_i = 1; los_i = 1; ais_i = 1;
        pulse(4'b1111, 3);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            check("R9 counts during alarm", v, 3);
        end
        lof_i = 0; los_i = 0; ais_i = 0;
    endtask

    task automatic t_latch();
        int v;
        cfg_latch_i = 1'b1;
        pulse(4'b0001, 10);
        pulse(4'b0010, 3);
        sec_tick_i = 1'b1;
        event_i    = 4'b0001;
        @(negedge clk);
        sec_tick_i = 1'b0;
        event_i    = '0;
        rd(3'd0, v); check("R6 framing held", v, 10);
        rd(3'd1, v); check("R6 crc held", v, 3);
        rd(3'd2, v); check("R6 lcv held", v, 0);
        rd(3'd0, v); check("R6 reread no clear", v, 10);
        pulse(4'b0001, 4);
        sec_tick_i = 1'b1;
        @(negedge clk);
        sec_tick_i = 1'b0;
        rd(3'd0, v); check("R7 new interval from 1", v, 5);
        rd(3'd1, v); check("R7 crc restarted", v, 0);
        sec_tick_i = 1'b1;
        @(negedge clk);
        sec_tick_i = 1'b0;
        cfg_latch_i = 1'b0;
    endtask

    task automatic t_flag();
        int v;
        check("R10 flag set by earlier tick", sec_irq_o, 1);
        rd(3'd4, v); check("R10 read flag", v, 1);
        check("R10 cleared", sec_irq_o, 0);
        rd(3'd4, v); check("R10 reread zero", v, 0);
        sec_tick_i = 1'b1;
        rd(3'd4, v);
        sec_tick_i = 1'b0;
        check("R10 read with tick", v, 0);
        check("R10 tick wins over clear", sec_irq_o, 1);
        rd(3'd4, v); check("R10 flag readable", v, 1);
        check("R10 clear after read", sec_irq_o, 0);
    endtask

    task automatic t_sat();
        int v;
        pulse(4'b0100, 65540);
        rd(3'd2, v); check("R3 saturated", v, 65535);
        rd(3'd2, v); check("R3 clear after saturation", v, 0);
    endtask

    task automatic t_unused();
        int v;
        pulse(4'b1111, 2);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v);
            check("R11 unused address", v, 0);
        end
        #1 check("R11 idle data", rd_data_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_collide();
        t_stop();
        t_nostop();
        t_latch();
        t_flag();
        t_sat();
        t_unused();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule